// File: doc/BRIEF.md
# Compressed Instruction Aligner

The aligner sits between a fetch path that delivers word-aligned 32-bit words and the decode stage. Instructions in the stream are either 16-bit compressed or 32-bit full encodings, and either kind may start on any halfword boundary. Each cycle the aligner picks the next instruction out of the presented word. It emits that instruction together with its program counter and a flag that says whether it is compressed.

A 32-bit instruction can start in the upper halfword of one word and end in the lower halfword of the next. The aligner keeps that upper halfword in a single holding register and joins it to the following word. A fetched word is accepted only once every instruction that starts in it has been issued. Any halfword that belongs to the next instruction is either still unread in the presented word or kept in the holding register.

A jump loads a new program counter, with bit 0 forced to zero. When the target is halfword-aligned, the aligner skips the low halfword of the first word it receives.

Top module: `instr_aligner`

## Requirements
- R1: After reset `instr_pc_o` equals the `RESET_PC` parameter with bit 0 cleared, and `instr_valid_o` is low while `fetch_valid_i` is low.
- R2: An instruction whose low two bits are not binary 11 is compressed. It is issued as `{16'h0000, halfword}` with `instr_compressed_o` = 1. Otherwise it is a 32-bit instruction, issued with its first halfword in bits 15:0 and `instr_compressed_o` = 0.
- R3: After each issued instruction (`instr_valid_o` and `instr_ready_i` both high) the program counter advances by 2 for a compressed instruction and by 4 for a full one.
- R4: A 32-bit instruction occupying a whole word is issued in the same cycle that the word is accepted (`fetch_ready_o` high).
- R5: When a word holds a compressed instruction in its low halfword, `fetch_ready_o` stays low while that instruction is issued. The word is accepted when its upper halfword's instruction is issued.
- R6: A 32-bit instruction starting in an upper halfword causes one cycle in which the word is accepted and nothing is issued. In the next cycle the instruction is issued as `{next_word[15:0], held_halfword}`, carrying the address of the upper halfword.
- R7: While words arrive every cycle and decode is always ready, an instruction is issued every cycle, except the one cycle of R6 per new straddling chain. If the upper half of the word completing a straddled instruction also starts a 32-bit instruction, that word is accepted in the same cycle.
- R8: In a cycle with `redirect_i` high, nothing is issued and no word is accepted. In the next cycle `instr_pc_o` holds the target. Any held halfword is discarded.
- R9: For a target with bit 1 set, the first instruction is taken from the upper halfword of the first word received.
- R10: With `instr_ready_i` low and an instruction on offer, no word is accepted and `instr_o` and `instr_pc_o` stay unchanged.
- R11: Bit 0 of `redirect_pc_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| redirect_i | input | 1 | Load a new program counter |
| redirect_pc_i | input | ADDR_W | Jump target, bit 0 ignored |
| fetch_valid_i | input | 1 | Fetched word available |
| fetch_data_i | input | 32 | Word-aligned fetched word |
| fetch_ready_o | output | 1 | Fetched word is accepted this cycle |
| instr_valid_o | output | 1 | Instruction offered to decode |
| instr_ready_i | input | 1 | Decode takes the offered instruction |
| instr_o | output | 32 | Instruction, compressed ones zero-extended |
| instr_pc_o | output | ADDR_W | Address of the offered instruction |
| instr_compressed_o | output | 1 | Offered instruction is 16-bit |

## Verification
Directed code sequences cover the distinct placements:
- two compressed instructions in one word, which separates a consumed word from a held one;
- an aligned full word, which tests same-cycle acceptance;
- a chain of straddling 32-bit instructions, which shows whether the join takes the right halves and keeps throughput;
- a halfword jump target, which shows whether the low half is skipped.

Randomly mixed compressed and full code is then run under random fetch gaps, decode stalls and redirects. Every issued instruction and address is compared with a walk of the program image. In every cycle without stalls, the bench also predicts whether an instruction must be issued, so an unexpected bubble is told apart from the one legal hold cycle.

// File: rtl/cia_pkg.sv
package cia_pkg;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    SRC_LO   = 2'd0,
    SRC_HI   = 2'd1,
    SRC_JOIN = 2'd2
  } src_e;

  typedef struct packed {
    logic out_v;    // an instruction is offered
    logic consume;  // presented word is retired on advance
    logic hold;     // next value of held-valid
    logic comp;     // offered instruction is compressed
    src_e src;
  } plan_t;
endpackage

// File: rtl/cia_len_detect.sv
module cia_len_detect #(
  parameter int unsigned HW = 16
) (
  input  logic [HW-1:0] half_i,
  output logic          full_o
);
  // 32-bit encodings have both low bits set
  assign full_o = &half_i[1:0];

  logic unused_hi;
  assign unused_hi = ^half_i[HW-1:2];
endmodule

// File: rtl/cia_plan.sv
module cia_plan
  import cia_pkg::*;
(
  input  logic  held_v_i,
  input  logic  at_hi_i,
  input  logic  full_lo_i,
  input  logic  full_hi_i,
  output plan_t plan_o
);
  always_comb begin
    plan_o = '0;
    plan_o.src = SRC_LO;
    if (held_v_i) begin
      // finish straddled instr; keep word if its upper half is compressed
      plan_o.out_v   = 1'b1;
      plan_o.src     = SRC_JOIN;
      plan_o.comp    = 1'b0;
      plan_o.consume = full_hi_i;
      plan_o.hold    = full_hi_i;
    end else if (!at_hi_i) begin
      plan_o.out_v   = 1'b1;
      plan_o.src     = SRC_LO;
      plan_o.comp    = !full_lo_i;
      plan_o.consume = full_lo_i;
      plan_o.hold    = 1'b0;
    end else begin
      plan_o.src     = SRC_HI;
      plan_o.out_v   = !full_hi_i;
      plan_o.comp    = !full_hi_i;
      plan_o.consume = 1'b1;
      plan_o.hold    = full_hi_i;
    end
  end
endmodule

// File: rtl/cia_assemble.sv
module cia_assemble
  import cia_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [HALF_W-1:0] held_i,
  input  src_e              src_i,
  input  logic              comp_i,
  output logic [WORD_W-1:0] instr_o
);
  localparam int unsigned PAD_W = WORD_W - HALF_W;

  always_comb begin
    unique case (src_i)
      SRC_JOIN: instr_o = {word_i[HALF_W-1:0], held_i};
      SRC_HI:   instr_o = {{PAD_W{1'b0}}, word_i[WORD_W-1:HALF_W]};
      default:  instr_o = comp_i ? {{PAD_W{1'b0}}, word_i[HALF_W-1:0]} : word_i;
    endcase
  end
endmodule

// File: rtl/instr_aligner.sv
module instr_aligner
  import cia_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              redirect_i,
  input  logic [ADDR_W-1:0] redirect_pc_i,
  input  logic              fetch_valid_i,
  input  logic [WORD_W-1:0] fetch_data_i,
  output logic              fetch_ready_o,
  output logic              instr_valid_o,
  input  logic              instr_ready_i,
  output logic [WORD_W-1:0] instr_o,
  output logic [ADDR_W-1:0] instr_pc_o,
  output logic              instr_compressed_o
);
  localparam int unsigned NHALF = WORD_W / HALF_W;
  localparam logic [ADDR_W-1:0] HW_MASK = ~ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STEP_C  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] STEP_F  = ADDR_W'(4);

  logic [ADDR_W-1:0] pc_q;
  logic [HALF_W-1:0] held_q;
  logic              held_v_q;
  logic [NHALF-1:0]  full_h;
  plan_t             plan;
  logic              adv;

  for (genvar g = 0; g < NHALF; g++) begin : g_len
    cia_len_detect #(.HW(HALF_W)) u_len (
      .half_i (fetch_data_i[g*HALF_W +: HALF_W]),
      .full_o (full_h[g])
    );
  end

  cia_plan u_plan (
    .held_v_i  (held_v_q),
    .at_hi_i   (pc_q[1]),
    .full_lo_i (full_h[0]),
    .full_hi_i (full_h[NHALF-1]),
    .plan_o    (plan)
  );

  cia_assemble u_asm (
    .word_i  (fetch_data_i),
    .held_i  (held_q),
    .src_i   (plan.src),
    .comp_i  (plan.comp),
    .instr_o (instr_o)
  );

  assign instr_valid_o      = plan.out_v && fetch_valid_i && !redirect_i;
  assign instr_compressed_o = plan.comp;
  assign instr_pc_o         = pc_q;
  assign fetch_ready_o      = !redirect_i && plan.consume && (!plan.out_v || instr_ready_i);
  assign adv = fetch_valid_i && !redirect_i && (!plan.out_v || instr_ready_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= RESET_PC & HW_MASK;
      held_q   <= '0;
      held_v_q <= 1'b0;
    end else if (redirect_i) begin
      pc_q     <= redirect_pc_i & HW_MASK;
      held_v_q <= 1'b0;
    end else if (adv) begin
      if (plan.out_v) pc_q <= pc_q + (plan.comp ? STEP_C : STEP_F);
      held_v_q <= plan.hold;
      if (plan.hold) held_q <= fetch_data_i[WORD_W-1:HALF_W];
    end
  end

  a_r3_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_o && instr_ready_i) |=>
      instr_pc_o == $past(instr_pc_o) + ($past(instr_compressed_o) ? STEP_C : STEP_F));

  a_r8_redirect_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |-> (!instr_valid_o && !fetch_ready_o));

  a_r8_redirect_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |=> instr_pc_o == ($past(redirect_pc_i) & HW_MASK));

  a_r2_len_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_o |-> (instr_compressed_o == (instr_o[1:0] != 2'b11)));

  a_r2_zero_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_o && instr_compressed_o) |-> (instr_o[WORD_W-1:HALF_W] == '0));

  a_r10_stall_keeps_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_o && !instr_ready_i) |-> !fetch_ready_o);

  a_r10_stall_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_o && !instr_ready_i && !redirect_i) |=> $stable(instr_pc_o));

  a_r11_pc_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_pc_o[0] == 1'b0);
endmodule

// File: tb/sim_instr_aligner.sv
module sim_instr_aligner;
  localparam int MEMH = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        redirect_i = 1'b0;
  logic [31:0] redirect_pc_i = '0;
  logic        fetch_valid_i = 1'b0;
  logic [31:0] fetch_data_i = '0;
  logic        fetch_ready_o;
  logic        instr_valid_o;
  logic        instr_ready_i = 1'b0;
  logic [31:0] instr_o;
  logic [31:0] instr_pc_o;
  logic        instr_compressed_o;

  always #5 clk = ~clk;

  instr_aligner u0 (
    .clk_i(clk), .rst_ni(rst_n), .redirect_i(redirect_i), .redirect_pc_i(redirect_pc_i),
    .fetch_valid_i(fetch_valid_i), .fetch_data_i(fetch_data_i), .fetch_ready_o(fetch_ready_o),
    .instr_valid_o(instr_valid_o), .instr_ready_i(instr_ready_i), .instr_o(instr_o),
    .instr_pc_o(instr_pc_o), .instr_compressed_o(instr_compressed_o)
  );

  logic [15:0] mem [MEMH];
  logic [31:0] fa, epc;
  int checks = 0, errors = 0, issued = 0;
  bit done = 0, after_redir = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return {mem[((a >> 1) + 1) % MEMH], mem[(a >> 1) % MEMH]};
  endfunction

  function automatic bit is_full(input logic [15:0] h);
    return h[1:0] == 2'b11;
  endfunction

  function automatic logic [31:0] exp_instr(input logic [31:0] a);
    logic [15:0] h0;
    h0 = mem[(a >> 1) % MEMH];
    if (is_full(h0)) return {mem[((a >> 1) + 1) % MEMH], h0};
    return {16'h0000, h0};
  endfunction

  task automatic drive(input bit fv, input bit rdy, input bit redir, input logic [31:0] tgt);
    @(negedge clk);
    fetch_valid_i = fv;
    fetch_data_i  = word_at(fa);
    instr_ready_i = rdy;
    redirect_i    = redir;
    redirect_pc_i = tgt;
    #1;
  endtask

  // updates the reference model from the current cycle's handshake
  task automatic commit(input bit bubble_chk);
    if (redirect_i) begin
      chk(!instr_valid_o && !fetch_ready_o, "R8 redirect cycle quiet",
          {30'd0, instr_valid_o, fetch_ready_o}, 32'd0);
      fa = redirect_pc_i & ~32'd3;
      epc = redirect_pc_i & ~32'd1;
      after_redir = 1;
    end else begin
      if (after_redir) begin
        chk(instr_pc_o == epc, "R8/R11 pc after redirect", instr_pc_o, epc);
        after_redir = 0;
      end
      if (bubble_chk && fetch_valid_i && instr_ready_i) begin
        bit hold_cyc;
        hold_cyc = (fa == (epc & ~32'd3)) && epc[1] && is_full(mem[(epc >> 1) % MEMH]);
        chk(instr_valid_o == !hold_cyc, "R7 issue every cycle", {31'd0, instr_valid_o}, {31'd0, !hold_cyc});
      end
      if (instr_valid_o && instr_ready_i) begin
        logic [31:0] ei;
        ei = exp_instr(epc);
        chk(instr_pc_o == epc, "R3 issued pc", instr_pc_o, epc);
        chk(instr_o == ei, "R2/R6 issued instr", instr_o, ei);
        chk(instr_compressed_o == !is_full(ei[15:0]), "R2 compressed flag",
            {31'd0, instr_compressed_o}, {31'd0, !is_full(ei[15:0])});
        epc = epc + (is_full(ei[15:0]) ? 32'd4 : 32'd2);
        issued++;
      end
      if (fetch_valid_i && fetch_ready_o) fa = fa + 32'd4;
    end
  endtask

  task automatic step(input bit fv, input bit rdy);
    drive(fv, rdy, 0, 32'd0);
    commit(1);
  endtask

  task automatic jump(input logic [31:0] tgt);
    drive(0, 1, 1, tgt);
    commit(0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] keep_i, keep_pc;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < MEMH; i++) begin
      logic [15:0] h;
      h = 16'($urandom);
      if ($urandom % 2 == 0) h[1:0] = 2'b11;
      else if (h[1:0] == 2'b11) h[1:0] = 2'b01;
      mem[i] = h;
    end
    // directed images
    mem[16'h100 >> 1] = 16'h0011; mem[16'h102 >> 1] = 16'h0022;
    mem[16'h104 >> 1] = 16'h0013; mem[16'h106 >> 1] = 16'hABCD;
    mem[16'h300 >> 1] = 16'h1235; mem[16'h302 >> 1] = 16'hA0B3;
    mem[16'h304 >> 1] = 16'hC0DE; mem[16'h306 >> 1] = 16'h5557;
    mem[16'h308 >> 1] = 16'h7777; mem[16'h30A >> 1] = 16'h2222;
    mem[16'h400 >> 1] = 16'h1113; mem[16'h402 >> 1] = 16'h0009;
    mem[16'h500 >> 1] = 16'h0005; mem[16'h502 >> 1] = 16'h8883;
    mem[16'h600 >> 1] = 16'h4001; mem[16'h602 >> 1] = 16'h0002;
    fa = 0; epc = 0;

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk(instr_pc_o == 32'd0, "R1 reset pc", instr_pc_o, 32'd0);
    chk(!instr_valid_o, "R1 no issue without data", {31'd0, instr_valid_o}, 32'd0);

    // two compressed, then aligned full word
    jump(32'h100);
    drive(1, 1, 0, 0);
    chk(instr_valid_o && instr_compressed_o && instr_o == 32'h0011, "R2/R5 low compressed", instr_o, 32'h0011);
    chk(!fetch_ready_o, "R5 word kept after low half", {31'd0, fetch_ready_o}, 32'd0);
    commit(1);
    drive(1, 1, 0, 0);
    chk(fetch_ready_o && instr_pc_o == 32'h102, "R5 word taken with upper half", instr_pc_o, 32'h102);
    commit(1);
    drive(1, 1, 0, 0);
    chk(fetch_ready_o && instr_valid_o && instr_o == 32'hABCD0013, "R4 aligned full same cycle", instr_o, 32'hABCD0013);
    commit(1);

    // straddling chain and backpressure
    jump(32'h300);
    step(1, 1);
    drive(1, 1, 0, 0);
    chk(!instr_valid_o && fetch_ready_o, "R6 hold cycle", {30'd0, instr_valid_o, fetch_ready_o}, 32'd1);
    commit(1);
    drive(1, 1, 0, 0);
    chk(instr_o == 32'hC0DEA0B3 && instr_pc_o == 32'h302, "R6 joined instr", instr_o, 32'hC0DEA0B3);
    chk(fetch_ready_o, "R7 word taken during join", {31'd0, fetch_ready_o}, 32'd1);
    commit(1);
    drive(1, 0, 0, 0);
    chk(instr_valid_o && !fetch_ready_o, "R10 stalled no accept", {30'd0, instr_valid_o, fetch_ready_o}, 32'd2);
    keep_i = instr_o; keep_pc = instr_pc_o;
    commit(1);
    drive(1, 0, 0, 0);
    chk(instr_o == keep_i && instr_pc_o == keep_pc, "R10 output stable", instr_o, keep_i);
    commit(1);
    drive(1, 1, 0, 0);
    chk(instr_o == 32'h77775557 && instr_pc_o == 32'h306, "R7 second join", instr_o, 32'h77775557);
    chk(!fetch_ready_o, "R7 word kept for upper compressed", {31'd0, fetch_ready_o}, 32'd0);
    commit(1);
    drive(1, 1, 0, 0);
    chk(instr_o == 32'h2222 && instr_pc_o == 32'h30A, "R3 pc after full", instr_pc_o, 32'h30A);
    commit(1);

    // halfword target with bit 0 set
    jump(32'h403);
    drive(1, 1, 0, 0);
    chk(instr_valid_o && instr_o == 32'h0009 && instr_pc_o == 32'h402, "R9/R11 low half skipped", instr_o, 32'h0009);
    commit(1);

    // redirect while a halfword is held
    jump(32'h500);
    step(1, 1);
    step(1, 1);
    jump(32'h600);
    drive(1, 1, 0, 0);
    chk(instr_o == 32'h4001 && instr_pc_o == 32'h600, "R8 held half dropped", instr_o, 32'h4001);
    commit(1);

    // random phase
    jump(32'h800);
    for (int c = 0; c < 4000; c++) begin
      if (fa > 32'hF80 || $urandom % 40 == 0) begin
        jump(32'h800 + ($urandom % 32'h600));
      end else begin
        step($urandom % 4 != 0, $urandom % 4 != 0);
      end
    end
    chk(issued > 1000, "R7 random throughput", issued, 32'd1000);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule